// File: doc/BRIEF.md
# UART Receive Error Classifier

This block sits behind an oversampled UART receive shifter. For every completed character it takes three mid-bit samples per data bit, three samples of the stop bit, the parity verdict, the overrun condition of the receive holding FIFO and the carrier-detect loss indication. From these it picks the one error that wins in a fixed priority order. One clock later it emits a status word: per-class flags, a write-character strobe, a close-buffer strobe, a masked interrupt pulse and a resynchronisation pulse. It also keeps saturating event counters for parity, framing, noise and break.

A four-state controller tracks the receive context. RUN is the normal state. HUNT is entered after a fatal error in multidrop mode; characters are ignored there until an address-match pulse, and that transition is named *rejoin*. BREAK covers the continuation of a break sequence. BREAK_PENDING holds the first break character seen under synchronous zero-stop tolerance. The transitions are:
- *abort*: RUN, BREAK or BREAK_PENDING to HUNT, on a fatal error in multidrop mode.
- *brk_enter*: to BREAK, on a detected break.
- *brk_hold*: BREAK to itself, on further break characters.
- *brk_arm*: RUN to BREAK_PENDING, on the first break character under tolerance.
- *resume*: any receive state to RUN, on an ordinary or non-fatal character.

Top module: `uart_rx_err_classifier`

## Requirements
- R1: Each bit value is the majority of its three samples. On a written character, `st_data` bit i is the majority of `data_smp[3i+2:3i]`, and the stop bit is the majority of `stop_smp`.
- R2: When `cd_lost` is high with a character, that character is classified as carrier loss. It raises `st_cd` and `close_buf`, is not written, and increments no counter.
- R3: A break character has all data bits 0 and a stop bit of 0. Outside BREAK it raises `st_br` and `close_buf`, is not written, increments the break counter once, and enters BREAK. Further break characters in BREAK produce no status and no count. Any other character leaves BREAK and is classified normally.
- R4: With `fifo_full` high, a non-break character raises `st_ov`, is written, and closes the buffer.
- R5: A stop bit of 0 raises `st_fr`, writes the character, closes the buffer and increments the framing counter. The parity verdict of that character is ignored.
- R6: With `par_err` high and no higher-priority error, the character raises `st_pr`, is written, closes the buffer and increments the parity counter.
- R7: If the three samples of any bit, stop included, are not all equal, `st_nz` is raised and the noise counter increments. The buffer is not closed for noise. Noise is never reported with `sync_mode` high or with carrier loss.
- R8: Priority is carrier loss, then break, then overrun, then framing, then parity. At most one of `st_cd`, `st_br`, `st_ov`, `st_fr` and `st_pr` is set, and only the winner's counter moves.
- R9: `irq` is a one-clock pulse equal to `close_buf` ANDed with `irq_en` as sampled with the character.
- R10: With `multidrop` high, carrier loss, overrun, parity, and framing without tolerance all enter HUNT (`hunt`=1). In HUNT, characters give no status and no count, and an `addr_match` pulse returns to RUN.
- R11: With `sync_mode` and `rzs_en` both high, a framing error pulses `resync` and does not enter HUNT. A break is then recognised only on the second consecutive break character. The first one is reported as a framing error.
- R12: Counters are CNT_W bits wide (default 16), saturate at all ones, and clear synchronously on `cnt_clr`.
- R13: All status outputs are registered. `st_valid` pulses exactly one clock after a `chr_valid` cycle that is classified, and reset leaves every output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| chr_valid | input | 1 | A completed character is presented |
| data_smp | input | 3*DATA_BITS | Three samples per data bit, bit i at [3i+2:3i] |
| stop_smp | input | 3 | Three samples of the stop bit |
| par_err | input | 1 | Parity mismatch from the shifter |
| cd_lost | input | 1 | Carrier detect dropped during the character |
| fifo_full | input | 1 | Holding FIFO still holds an unread character |
| sync_mode | input | 1 | Synchronous receive mode |
| rzs_en | input | 1 | Zero-stop-bit tolerance (effective with sync_mode) |
| multidrop | input | 1 | Automatic multidrop mode |
| addr_match | input | 1 | Leave HUNT |
| irq_en | input | 1 | Interrupt enable (mask) |
| st_valid | output | 1 | Status below is valid this cycle |
| st_data | output | DATA_BITS | Majority-voted character |
| wr_char | output | 1 | Character is written to the buffer |
| st_cd | output | 1 | Carrier loss |
| st_br | output | 1 | Break |
| st_ov | output | 1 | Overrun |
| st_fr | output | 1 | Framing error |
| st_pr | output | 1 | Parity error |
| st_nz | output | 1 | Noise seen |
| close_buf | output | 1 | Close the receive buffer |
| irq | output | 1 | Masked interrupt pulse |
| resync | output | 1 | Treat the zero stop as the next start bit |
| hunt | output | 1 | Controller is in HUNT |
| cnt_par | output | CNT_W | Parity error count |
| cnt_frm | output | CNT_W | Framing error count |
| cnt_nse | output | CNT_W | Noise count |
| cnt_brk | output | CNT_W | Break count |

## Verification
The assertions check on every cycle that the fatal flags are mutually exclusive and that carrier loss never writes. They also check that an interrupt implies a close and an enabled mask, that noise is never reported in synchronous mode, and that HUNT stays silent. Counter monotonicity, saturation and clearing are checked the same way. The correctness of the priority decision for each input combination, break-sequence continuation, the two-character break rule under tolerance, and the exact counter totals can only be shown by the bench. It sweeps every combination of the error inputs and mode bits from RUN and compares against an arithmetic model.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_HUNT,
        ST_BRK,
        ST_BRKP
    } rxe_state_t;

    typedef enum logic [2:0] {
        CL_OK,
        CL_CD,
        CL_BR,
        CL_OV,
        CL_FR,
        CL_PR,
        CL_SILENT
    } rxe_class_t;
endpackage

// File: rtl/rxe_voter.sv
module rxe_voter #(
    parameter int N = 9
) (
    input  logic [3*N-1:0] smp,
    output logic [N-1:0]   bit_val,
    output logic           noisy
);
    logic [N-1:0] disagree;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic a, b, c;
        assign a = smp[3*i];
        assign b = smp[3*i+1];
        assign c = smp[3*i+2];
        assign bit_val[i]  = (a & b) | (a & c) | (b & c);
        assign disagree[i] = (a ^ b) | (b ^ c);
    end

    assign noisy = |disagree;
endmodule

// File: rtl/rxe_satcnt.sv
module rxe_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end

    // R12: counter holds at all ones
    a_r12_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !clr) |=> cnt == MAXV);
    // R12: synchronous clear
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    // R12: never decreases without clear
    a_r12_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/uart_rx_err_classifier.sv
module uart_rx_err_classifier
    import rxe_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cnt_clr,
    input  logic                   chr_valid,
    input  logic [3*DATA_BITS-1:0] data_smp,
    input  logic [2:0]             stop_smp,
    input  logic                   par_err,
    input  logic                   cd_lost,
    input  logic                   fifo_full,
    input  logic                   sync_mode,
    input  logic                   rzs_en,
    input  logic                   multidrop,
    input  logic                   addr_match,
    input  logic                   irq_en,
    output logic                   st_valid,
    output logic [DATA_BITS-1:0]   st_data,
    output logic                   wr_char,
    output logic                   st_cd,
    output logic                   st_br,
    output logic                   st_ov,
    output logic                   st_fr,
    output logic                   st_pr,
    output logic                   st_nz,
    output logic                   close_buf,
    output logic                   irq,
    output logic                   resync,
    output logic                   hunt,
    output logic [CNT_W-1:0]       cnt_par,
    output logic [CNT_W-1:0]       cnt_frm,
    output logic [CNT_W-1:0]       cnt_nse,
    output logic [CNT_W-1:0]       cnt_brk
);
    localparam int NB = DATA_BITS + 1;

    rxe_state_t            state, nstate;
    rxe_class_t            cls;
    logic                  do_resync;
    logic [NB-1:0]         bits;
    logic                  noisy;
    logic [DATA_BITS-1:0]  dat;
    logic                  stop_bit, is_brk, rzs, take, nz_ev;

    rxe_voter #(.N(NB)) u_vote (
        .smp     ({stop_smp, data_smp}),
        .bit_val (bits),
        .noisy   (noisy)
    );

    assign dat      = bits[DATA_BITS-1:0];
    assign stop_bit = bits[DATA_BITS];
    assign is_brk   = (dat == '0) && !stop_bit;
    assign rzs      = sync_mode && rzs_en;
    assign hunt     = (state == ST_HUNT);

    // decision and next state
    always_comb begin
        cls       = CL_SILENT;
        nstate    = state;
        do_resync = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (addr_match) nstate = ST_RUN;             // rejoin
            end
            ST_RUN, ST_BRK, ST_BRKP: begin
                if (chr_valid) begin
                    if (cd_lost) begin
                        cls    = CL_CD;
                        nstate = multidrop ? ST_HUNT : ST_RUN;   // abort / resume
                    end else if (is_brk) begin
                        if (state == ST_BRK) begin
                            cls    = CL_SILENT;
                            nstate = ST_BRK;                      // brk_hold
                        end else if (rzs && state != ST_BRKP) begin
                            cls       = CL_FR;
                            do_resync = 1'b1;
                            nstate    = ST_BRKP;                  // brk_arm
                        end else begin
                            cls    = CL_BR;
                            nstate = ST_BRK;                      // brk_enter
                        end
                    end else if (fifo_full) begin
                        cls    = CL_OV;
                        nstate = multidrop ? ST_HUNT : ST_RUN;
                    end else if (!stop_bit) begin
                        cls       = CL_FR;
                        do_resync = rzs;
                        nstate    = (multidrop && !rzs) ? ST_HUNT : ST_RUN;
                    end else if (par_err) begin
                        cls    = CL_PR;
                        nstate = multidrop ? ST_HUNT : ST_RUN;
                    end else begin
                        cls    = CL_OK;
                        nstate = ST_RUN;
                    end
                end
            end
        endcase
    end

    assign take  = (cls != CL_SILENT);
    assign nz_ev = take && (cls != CL_CD) && !sync_mode && noisy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nstate;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_valid  <= 1'b0;
            st_data   <= '0;
            wr_char   <= 1'b0;
            st_cd     <= 1'b0;
            st_br     <= 1'b0;
            st_ov     <= 1'b0;
            st_fr     <= 1'b0;
            st_pr     <= 1'b0;
            st_nz     <= 1'b0;
            close_buf <= 1'b0;
            irq       <= 1'b0;
            resync    <= 1'b0;
        end else begin
            st_valid  <= take;
            st_data   <= dat;
            wr_char   <= (cls == CL_OK) || (cls == CL_OV) ||
                         (cls == CL_FR) || (cls == CL_PR);
            st_cd     <= (cls == CL_CD);
            st_br     <= (cls == CL_BR);
            st_ov     <= (cls == CL_OV);
            st_fr     <= (cls == CL_FR);
            st_pr     <= (cls == CL_PR);
            st_nz     <= nz_ev;
            close_buf <= take && (cls != CL_OK);
            irq       <= take && (cls != CL_OK) && irq_en;
            resync    <= do_resync;
        end
    end

    rxe_satcnt #(.W(CNT_W)) u_cpar (.clk(clk), .rst_n(rst_n), .clr(cnt_clr),
                                    .inc(cls == CL_PR), .cnt(cnt_par));
    rxe_satcnt #(.W(CNT_W)) u_cfrm (.clk(clk), .rst_n(rst_n), .clr(cnt_clr),
                                    .inc(cls == CL_FR), .cnt(cnt_frm));
    rxe_satcnt #(.W(CNT_W)) u_cnse (.clk(clk), .rst_n(rst_n), .clr(cnt_clr),
                                    .inc(nz_ev), .cnt(cnt_nse));
    rxe_satcnt #(.W(CNT_W)) u_cbrk (.clk(clk), .rst_n(rst_n), .clr(cnt_clr),
                                    .inc(cls == CL_BR), .cnt(cnt_brk));

    // R8: fatal classes are exclusive
    a_r8_one_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_cd, st_br, st_ov, st_fr, st_pr}));
    // R2: carrier loss discards the character
    a_r2_cd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_cd |-> !wr_char && close_buf);
    // R9: interrupt needs a close and an enabled mask
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> close_buf && $past(irq_en));
    // R7: no noise in synchronous mode
    a_r7_nz_async: assert property (@(posedge clk) disable iff (!rst_n)
        st_nz |-> !$past(sync_mode));
    // R10: HUNT emits nothing
    a_r10_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> !st_valid);
    // R10: multidrop fatal errors enter HUNT
    a_r10_md_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && $past(multidrop) && (st_cd || st_ov || st_pr)) |-> hunt);
    // R13: status follows a presented character
    a_r13_follows: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(chr_valid));
endmodule

// File: tb/tb_uart_rx_err_classifier.sv
`timescale 1ns/1ps
module tb_uart_rx_err_classifier;
    localparam int DB = 8;
    localparam int CW = 6;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, cnt_clr = 1'b0, chr_valid = 1'b0;
    logic [3*DB-1:0] data_smp = '0;
    logic [2:0] stop_smp = 3'b111;
    logic par_err = 0, cd_lost = 0, fifo_full = 0, sync_mode = 0, rzs_en = 0;
    logic multidrop = 0, addr_match = 0, irq_en = 0;
    logic st_valid, wr_char, st_cd, st_br, st_ov, st_fr, st_pr, st_nz;
    logic close_buf, irq, resync, hunt;
    logic [DB-1:0] st_data;
    logic [CW-1:0] cnt_par, cnt_frm, cnt_nse, cnt_brk;

    int tests = 0, fails = 0;
    int e_par = 0, e_frm = 0, e_nse = 0, e_brk = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_rx_err_classifier #(.DATA_BITS(DB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .chr_valid(chr_valid),
        .data_smp(data_smp), .stop_smp(stop_smp), .par_err(par_err),
        .cd_lost(cd_lost), .fifo_full(fifo_full), .sync_mode(sync_mode),
        .rzs_en(rzs_en), .multidrop(multidrop), .addr_match(addr_match),
        .irq_en(irq_en), .st_valid(st_valid), .st_data(st_data),
        .wr_char(wr_char), .st_cd(st_cd), .st_br(st_br), .st_ov(st_ov),
        .st_fr(st_fr), .st_pr(st_pr), .st_nz(st_nz), .close_buf(close_buf),
        .irq(irq), .resync(resync), .hunt(hunt), .cnt_par(cnt_par),
        .cnt_frm(cnt_frm), .cnt_nse(cnt_nse), .cnt_brk(cnt_brk));

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= MAXC) ? MAXC : v + 1;
    endfunction

    // present one character; outputs checked one clock later at the negedge
    task automatic send(input logic [DB-1:0] d, input bit stop_ok, input bit nz,
                        input bit cd, input bit ov, input bit par, input bit ie);
        @(negedge clk);
        for (int i = 0; i < DB; i++) data_smp[3*i +: 3] = {3{d[i]}};
        if (nz) data_smp[3*3 + 1] = ~data_smp[3*3 + 1];
        stop_smp  = stop_ok ? 3'b111 : 3'b000;
        cd_lost   = cd; fifo_full = ov; par_err = par; irq_en = ie;
        chr_valid = 1'b1;
        @(negedge clk);
        chr_valid = 1'b0; cd_lost = 0; fifo_full = 0; par_err = 0;
    endtask

    task automatic check_counters(input string req);
        check({req, " cnt_par"}, cnt_par, e_par);
        check({req, " cnt_frm"}, cnt_frm, e_frm);
        check({req, " cnt_nse"}, cnt_nse, e_nse);
        check({req, " cnt_brk"}, cnt_brk, e_brk);
    endtask

    task automatic return_to_run();
        @(negedge clk); addr_match = 1'b1;
        @(negedge clk); addr_match = 1'b0;
        sync_mode = 0; rzs_en = 0; multidrop = 0;
        send(8'h55, 1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset st_valid", st_valid, 0);
        check("R13 reset close_buf", close_buf, 0);
        check("R13 reset irq", irq, 0);
        check("R13 reset hunt", hunt, 0);
        check_counters("R13 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of all error inputs and mode bits from RUN (R1..R11)
        for (int p = 0; p < 512; p++) begin
            bit cd, ov, stb, par, sy, rz, md, nz, brk, ie, rzs;
            bit e_cd, e_br, e_ov, e_fr, e_pr, e_nz, e_wr, e_cl, e_hunt;
            logic [DB-1:0] d;
            cd = p[0]; ov = p[1]; stb = p[2]; par = p[3]; sy = p[4];
            rz = p[5]; md = p[6]; nz = p[7]; brk = p[8];
            ie = p[0] ^ p[4] ^ p[7] ^ p[2];
            rzs = sy & rz;
            d = brk ? 8'h00 : (8'(p * 37 + 5) | 8'h01);
            e_cd = 0; e_br = 0; e_ov = 0; e_fr = 0; e_pr = 0;
            if (cd) e_cd = 1;
            else if (brk) begin if (rzs) e_fr = 1; else e_br = 1; end
            else if (ov) e_ov = 1;
            else if (stb) e_fr = 1;
            else if (par) e_pr = 1;
            e_nz = nz && !sy && !cd;
            e_wr = !e_cd && !e_br;
            e_cl = e_cd | e_br | e_ov | e_fr | e_pr;
            e_hunt = md && (e_cd || e_ov || e_pr || (e_fr && !rzs));
            sync_mode = sy; rzs_en = rz; multidrop = md;
            send(d, brk ? 1'b0 : !stb, nz, cd, ov, par, ie);
            if (e_pr) e_par = sat(e_par);
            if (e_fr) e_frm = sat(e_frm);
            if (e_nz) e_nse = sat(e_nse);
            if (e_br) e_brk = sat(e_brk);
            check("R13 st_valid", st_valid, 1);
            check("R8 flags {cd,br,ov,fr,pr}",
                  {st_cd, st_br, st_ov, st_fr, st_pr},
                  {e_cd, e_br, e_ov, e_fr, e_pr});
            check("R2/R3 wr_char", wr_char, e_wr);
            check("R4/R5/R6 close_buf", close_buf, e_cl);
            check("R7 st_nz", st_nz, e_nz);
            check("R9 irq", irq, e_cl & ie);
            check("R11 resync", resync, e_fr & rzs);
            check("R10 hunt", hunt, e_hunt);
            if (e_wr) check("R1 st_data", st_data, d);
            check_counters("R12 sweep");
            return_to_run();
        end

        // R3: async break sequence counted once, continuation silent
        send(8'h00, 0, 0, 0, 0, 0, 1);
        e_brk = sat(e_brk);
        check("R3 first break st_br", st_br, 1);
        check("R3 first break irq", irq, 1);
        send(8'h00, 0, 0, 0, 0, 0, 1);
        check("R3 continuation silent", st_valid, 0);
        send(8'h00, 0, 0, 0, 0, 0, 1);
        check("R3 continuation silent 2", st_valid, 0);
        check("R3 cnt_brk once", cnt_brk, e_brk);
        send(8'hA5, 1, 0, 0, 0, 0, 0);
        check("R3 exit break valid", st_valid, 1);
        check("R3 exit break data", st_data, 8'hA5);
        check("R3 exit break no close", close_buf, 0);

        // R11: two-character break rule under tolerance
        sync_mode = 1; rzs_en = 1;
        send(8'h00, 0, 0, 0, 0, 0, 0);
        e_frm = sat(e_frm);
        check("R11 first break as framing", st_fr, 1);
        check("R11 first break resync", resync, 1);
        send(8'h00, 0, 0, 0, 0, 0, 0);
        e_brk = sat(e_brk);
        check("R11 second break st_br", st_br, 1);
        send(8'h00, 0, 0, 0, 0, 0, 0);
        check("R11 third break silent", st_valid, 0);
        check_counters("R11");
        sync_mode = 0; rzs_en = 0;
        send(8'h3C, 1, 0, 0, 0, 0, 0);

        // R10: HUNT ignores characters until address match
        multidrop = 1;
        send(8'h12, 1, 0, 0, 0, 1, 0);
        e_par = sat(e_par);
        check("R10 parity enters hunt", hunt, 1);
        send(8'h34, 0, 1, 0, 0, 1, 1);
        check("R10 hunt ignores char", st_valid, 0);
        check("R10 hunt no irq", irq, 0);
        check_counters("R10 hunt no count");
        @(negedge clk); addr_match = 1;
        @(negedge clk); addr_match = 0;
        check("R10 rejoin", hunt, 0);
        send(8'h56, 1, 0, 0, 0, 0, 0);
        check("R10 after rejoin valid", st_valid, 1);
        check("R10 after rejoin data", st_data, 8'h56);
        multidrop = 0;

        // R12: saturation and clear
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        e_par = 0; e_frm = 0; e_nse = 0; e_brk = 0;
        check_counters("R12 clear");
        for (int k = 0; k < MAXC + 6; k++) send(8'h77, 1, 1, 0, 0, 1, 0);
        check("R12 parity saturates", cnt_par, MAXC);
        check("R12 noise saturates", cnt_nse, MAXC);
        check("R12 framing untouched", cnt_frm, 0);
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0;
        check("R12 clear after saturate", cnt_par, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule